// File: doc/BRIEF.md
# Inter-processor interrupt register block

This block is the interrupt agent that one processor uses to signal its peers and to collect signals from them. Software reaches it over a simple 32-bit register bus. A write to the trigger register sends a one-cycle pulse on any of eleven outgoing request lines. Requests that arrive on eleven incoming lines are latched into a status register. Software clears that register one bit at a time. The status is filtered by a mask to form a single interrupt output.

The latched status is also driven back to the senders on observation outputs. A second set of observation inputs carries the same kind of feedback from the targets of this agent's own requests, so software can tell whether a request it sent is still pending. The mask cannot be written directly. It changes only through a separate enable register and a separate disable register.

Top module: `ipi_agent`

## Requirements
- R1: Channel c (0..10) sits at word bit 0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27 respectively. Every other bit reads as zero in every register and has no effect when written.
- R2: A write to offset 0x00 drives trig_out[c] high for exactly one cycle, the cycle after the write is accepted, for each channel whose bit is 1 in the written word. Offset 0x00 always reads as zero.
- R3: A request that is high on req_in[c] at a clock edge sets status bit c (read at offset 0x10), and the bit stays set until it is cleared.
- R4: Writing 1 to a status channel bit at offset 0x10 clears it, and writing 0 leaves it unchanged.
- R5: If req_in[c] is high in the same cycle that software writes 1 to clear status bit c, the bit stays 1.
- R6: obs_out[c] equals status bit c at all times.
- R7: Offset 0x04 reads obs_in as sampled at the previous clock edge, and writes to it are ignored.
- R8: The mask (read at offset 0x14) resets to 0x0F0F0301, so every channel starts masked, and direct writes to it are ignored.
- R9: Writing offset 0x18 clears the mask bits set in the written word, and writing offset 0x1C sets them. Both offsets read as zero.
- R10: irq is high exactly when some channel has its status bit set and its mask bit clear.
- R11: Reads of any other offset, and of any address not a multiple of four, return zero, and writes to them change nothing.
- R12: After reset, status is zero, trig_out is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| req_in | input | 11 | Incoming request lines, one per channel |
| obs_in | input | 11 | Feedback from targets of own requests |
| trig_out | output | 11 | Outgoing one-cycle request pulses |
| obs_out | output | 11 | Latched status mirrored to senders |
| irq | output | 1 | Masked interrupt output |

## Verification
A wrong status bit appears on obs_out in the cycle after the edge that corrupted it, and it appears on irq in that same cycle whenever the channel is unmasked. A wrong mask bit stays hidden until its channel latches a request, so the bench unmasks channels and injects requests to bring mask errors out on irq. A trigger pulse that sticks or lands on the wrong channel shows on trig_out one cycle after the write.

// File: rtl/ipi_pkg.sv
// Shared constants, channel/bit-position mapping and register selector type
// for the inter-processor interrupt agent.
// Assumes the eleven-channel sparse layout is fixed by the system map.
package ipi_pkg;

    localparam int NUM_CH = 11;
    localparam int DATA_W = 32;

    // Word offsets (byte offset / 4) of the mapped registers.
    localparam int OFF_TRIG = 0;
    localparam int OFF_OBS  = 1;
    localparam int OFF_STAT = 4;
    localparam int OFF_MASK = 5;
    localparam int OFF_UNMK = 6;
    localparam int OFF_SETM = 7;

    localparam logic [DATA_W-1:0] CH_WORD_MASK = 32'h0F0F_0301;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TRIG,
        SEL_OBS,
        SEL_STAT,
        SEL_MASK,
        SEL_UNMK,
        SEL_SETM
    } reg_sel_e;

    // Bit position of channel c inside a register word.
    function automatic int chan_pos(input int c);
        if (c == 0)      return 0;
        else if (c < 3)  return c + 7;
        else if (c < 7)  return c + 13;
        else             return c + 17;
    endfunction

    // Spread a channel vector into its sparse word layout.
    function automatic logic [DATA_W-1:0] chan_to_word(input logic [NUM_CH-1:0] ch);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            w[chan_pos(c)] = ch[c];
        end
        return w;
    endfunction

    // Gather the channel bits out of a word; reserved bits are dropped.
    function automatic logic [NUM_CH-1:0] word_to_chan(input logic [DATA_W-1:0] w);
        logic [NUM_CH-1:0] ch;
        for (int c = 0; c < NUM_CH; c++) begin
            ch[c] = w[chan_pos(c)];
        end
        return ch;
    endfunction

endpackage

// File: rtl/ipi_decode.sv
// Address decoder: turns a bus access into a register selector.
// Assumes word-aligned byte addresses; misaligned or unmapped accesses
// select nothing.
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          sel
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             aligned;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    // Map the word index of a valid, aligned access onto a register.
    always_comb begin
        sel = SEL_NONE;
        if (bus_valid && aligned) begin
            case (word_idx)
                IDX_W'(OFF_TRIG): sel = SEL_TRIG;
                IDX_W'(OFF_OBS):  sel = SEL_OBS;
                IDX_W'(OFF_STAT): sel = SEL_STAT;
                IDX_W'(OFF_MASK): sel = SEL_MASK;
                IDX_W'(OFF_UNMK): sel = SEL_UNMK;
                IDX_W'(OFF_SETM): sel = SEL_SETM;
                default:          sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ipi_status.sv
// Latched request status with write-one-to-clear.
// Assumes req is synchronous to clk; a set and a clear of the same bit in
// one cycle leave the bit set.
module ipi_status #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] stat
);

    logic [N-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_bits : '0;

    // Clear the written ones, then let new requests win.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_eff) | req;
    end

endmodule

// File: rtl/ipi_mask.sv
// Interrupt mask changed only through separate unmask and set-mask writes.
// Assumes the two write strobes are never active together (one bus access
// per cycle).
module ipi_mask #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         unmask_en,
    input  logic         setmask_en,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);

    // Start fully masked; clear or set selected bits on the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask <= '1;
        else if (unmask_en)  mask <= mask & ~bits;
        else if (setmask_en) mask <= mask | bits;
    end

endmodule

// File: rtl/ipi_trig.sv
// Trigger pulse generator: one-cycle pulses per written channel bit.
// Assumes a new write in the pulse cycle simply produces the next pulse.
module ipi_trig #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  logic [N-1:0] bits,
    output logic [N-1:0] pulse
);

    // Hold the written bits for a single cycle, else return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    pulse <= '0;
        else if (fire) pulse <= bits;
        else           pulse <= '0;
    end

endmodule

// File: rtl/ipi_agent.sv
// Inter-processor interrupt agent: register decode, trigger pulses,
// latched status, mask control, observation feedback and interrupt.
// Assumes one bus access per cycle and all inputs synchronous to clk.
module ipi_agent
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [10:0]       req_in,
    input  logic [10:0]       obs_in,
    output logic [10:0]       trig_out,
    output logic [10:0]       obs_out,
    output logic              irq
);

    reg_sel_e          sel;
    logic              wr;
    logic [NUM_CH-1:0] wbits;
    logic [NUM_CH-1:0] stat_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] obs_q;

    assign wr    = bus_valid && bus_write;
    assign wbits = word_to_chan(bus_wdata);

    ipi_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .sel       (sel)
    );

    ipi_trig #(.N(NUM_CH)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (wr && sel == SEL_TRIG),
        .bits  (wbits),
        .pulse (trig_out)
    );

    ipi_status #(.N(NUM_CH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_in),
        .clr_en   (wr && sel == SEL_STAT),
        .clr_bits (wbits),
        .stat     (stat_q)
    );

    ipi_mask #(.N(NUM_CH)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .unmask_en  (wr && sel == SEL_UNMK),
        .setmask_en (wr && sel == SEL_SETM),
        .bits       (wbits),
        .mask       (mask_q)
    );

    // Sample the target feedback lines for software to read.
    always_ff @(posedge clk) begin
        if (!rst_n) obs_q <= '0;
        else        obs_q <= obs_in;
    end

    assign obs_out = stat_q;
    assign irq     = |(stat_q & ~mask_q);

    // Return the selected register in its sparse layout; others read zero.
    always_comb begin
        bus_rdata = '0;
        if (!bus_write) begin
            case (sel)
                SEL_OBS:  bus_rdata = chan_to_word(obs_q);
                SEL_STAT: bus_rdata = chan_to_word(stat_q);
                SEL_MASK: bus_rdata = chan_to_word(mask_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ipi_agent_checker.sv
// Protocol checker for ipi_agent, attached by bind below.
module ipi_agent_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [10:0]       req_in,
    input logic [10:0]       trig_out,
    input logic [10:0]       obs_out,
    input logic              irq,
    input logic [10:0]       mask
);

    logic wr_trig, wr_stat, wr_mask_ctl, rd;

    assign wr_trig     = bus_valid && bus_write && bus_addr == ADDR_W'(8'h00);
    assign wr_stat     = bus_valid && bus_write && bus_addr == ADDR_W'(8'h10);
    assign wr_mask_ctl = bus_valid && bus_write &&
                         (bus_addr == ADDR_W'(8'h18) || bus_addr == ADDR_W'(8'h1C));
    assign rd          = bus_valid && !bus_write;

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> ((bus_rdata & 32'hF0F0_FCFE) == 32'h0));

    assert_trig_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_out != '0) && !wr_trig) |=> (trig_out == '0));

    // Also covers R5: a request wins over a same-cycle clear.
    assert_req_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_in != '0) |=> ((obs_out & $past(req_in)) == $past(req_in)));

    assert_clear_only_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(obs_out) & ~obs_out) != '0) |-> $past(wr_stat));

    assert_mask_only_ctl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask_ctl |=> $stable(mask));

    assert_no_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (obs_out == '0) |-> !irq);

endmodule

bind ipi_agent ipi_agent_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .req_in    (req_in),
    .trig_out  (trig_out),
    .obs_out   (obs_out),
    .irq       (irq),
    .mask      (mask_q)
);

// File: tb/test_ipi_agent.sv
module test_ipi_agent;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [10:0]       req_in = '0;
    logic [10:0]       obs_in = '0;
    logic [10:0]       trig_out;
    logic [10:0]       obs_out;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [10:0] stat_m;
    logic [10:0] mask_m;
    logic [10:0] obs_m;

    ipi_agent #(.ADDR_W(ADDR_W)) i_ipi_agent (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_in(req_in), .obs_in(obs_in), .trig_out(trig_out),
        .obs_out(obs_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Channel positions as given in R1.
    function automatic int pos_of(input int c);
        int p [11] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};
        return p[c];
    endfunction

    function automatic logic [31:0] spread(input logic [10:0] ch);
        logic [31:0] w = '0;
        for (int c = 0; c < 11; c++) w[pos_of(c)] = ch[c];
        return w;
    endfunction

    function automatic logic [10:0] gather(input logic [31:0] w);
        logic [10:0] ch;
        for (int c = 0; c < 11; c++) ch[c] = w[pos_of(c)];
        return ch;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // One cycle of stimulus: optional request lines plus optional write.
    task automatic step(input logic [10:0] req, input bit wr,
                        input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [10:0] b;
        b = gather(d);
        @(negedge clk);
        req_in = req; bus_valid = wr; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        req_in = '0; bus_valid = 1'b0; bus_write = 1'b0;
        if (wr && a == 8'h10) stat_m = stat_m & ~b;
        if (wr && a == 8'h18) mask_m = mask_m & ~b;
        if (wr && a == 8'h1C) mask_m = mask_m | b;
        stat_m = stat_m | req;
        if (wr && a == 8'h00) begin
            chk("R2 pulse", {21'b0, trig_out}, {21'b0, b});
            @(negedge clk);
            chk("R2 pulse end", {21'b0, trig_out}, 32'h0);
        end else begin
            chk("R2 idle", {21'b0, trig_out}, 32'h0);
        end
    endtask

    task automatic verify_all();
        logic [31:0] d;
        rd(8'h00, d); chk("R2 read zero", d, 32'h0);
        rd(8'h04, d); chk("R7 obs read", d, spread(obs_m));
        rd(8'h10, d); chk("R3 R4 status read", d, spread(stat_m));
        rd(8'h14, d); chk("R8 R9 mask read", d, spread(mask_m));
        rd(8'h18, d); chk("R9 unmask reads zero", d, 32'h0);
        rd(8'h1C, d); chk("R9 setmask reads zero", d, 32'h0);
        chk("R6 obs_out", {21'b0, obs_out}, {21'b0, stat_m});
        chk("R10 irq", {31'b0, irq}, {31'b0, |(stat_m & ~mask_m)});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [ADDR_W-1:0] addrs [6] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h18, 8'h1C};
        void'($urandom(32'd7341));
        stat_m = '0; mask_m = '1; obs_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 / R8: reset state.
        chk("R12 trig after reset", {21'b0, trig_out}, 32'h0);
        chk("R12 irq after reset", {31'b0, irq}, 32'h0);
        rd(8'h10, d); chk("R12 status after reset", d, 32'h0);
        rd(8'h14, d); chk("R8 mask reset", d, 32'h0F0F_0301);

        // R1: reserved-only writes do nothing.
        step('0, 1'b1, 8'h18, 32'hF0F0_FCFE);
        step('0, 1'b1, 8'h00, 32'hF0F0_FCFE);
        verify_all();

        // R8: direct mask write ignored; R7: obs write ignored.
        step('0, 1'b1, 8'h14, 32'h0);
        obs_in = 11'h5A5; obs_m = 11'h5A5;
        step('0, 1'b1, 8'h04, 32'h0);
        verify_all();

        // R10: unmask channel 3, raise it.
        step('0, 1'b1, 8'h18, spread(11'h008));
        step(11'h008, 1'b0, 8'h00, 32'h0);
        verify_all();

        // R5: request and clear of same bit together.
        step(11'h008, 1'b1, 8'h10, spread(11'h008));
        verify_all();
        // R4: clear with a zero leaves, with a one clears.
        step('0, 1'b1, 8'h10, 32'h0);
        verify_all();
        step('0, 1'b1, 8'h10, spread(11'h008));
        verify_all();

        // R11: unmapped and misaligned accesses.
        step('0, 1'b1, 8'h08, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h20, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h12, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h1A, 32'hFFFF_FFFF);
        rd(8'h08, d); chk("R11 unmapped read", d, 32'h0);
        rd(8'h11, d); chk("R11 misaligned read", d, 32'h0);
        rd(8'hFC, d); chk("R11 high read", d, 32'h0);
        verify_all();

        // R2: every channel triggered at once.
        step('0, 1'b1, 8'h00, 32'hFFFF_FFFF);

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic [10:0] rq;
            bit          w;
            rq = ($urandom % 3 == 0) ? 11'($urandom) : 11'h0;
            w  = ($urandom % 4 != 0);
            if ($urandom % 5 == 0) begin
                obs_in = 11'($urandom);
                obs_m  = obs_in;
            end
            step(rq, w, addrs[$urandom % 6], $urandom);
            verify_all();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule